// File: doc/BRIEF.md
# Worst-case error threshold guard

This block decides, for one pair of unsigned results at a time, whether an approximate result strays from the exact result by more than a fixed tolerance. It takes an exact value and an approximate value of the same width, forms their signed difference one bit wider than the operands, and raises a single violation bit when the magnitude of that difference is larger than the tolerance `THRESH`. It never forms an absolute value and uses no general magnitude comparator. Instead it tests the two signs of the difference separately, each against a constant fixed at elaboration, with plain AND/OR terms.

When the difference is non-negative, the low bits are compared against `THRESH`. When it is negative, the inverted low bits are compared against `THRESH - 1`; this works because the magnitude equals the inverted difference plus one. For `THRESH = 0` the negative side is always a violation, since a negative difference is never zero. The tolerance may be any value from 0 to `2**W - 1`.

Operands enter through a valid/ready stream, and the verdict leaves through a second one. A beat is taken on a clock edge where `in_valid` and `in_ready` are both high. The verdict appears on the following cycle and stays put until the consumer takes it. `in_ready` is high whenever the output register is empty or is being drained in that same cycle. A stalled verdict therefore holds back new input, and input can flow every cycle while `out_ready` stays high.

Top module: `wce_guard`

## Requirements
- R1: For every accepted beat, `out_flag` equals 1 exactly when the absolute value of (`golden` - `approx`) is greater than `THRESH`, with both operands read as unsigned `W`-bit numbers.
- R2: When `golden` is above `approx`, the flag is set only when the difference is greater than `THRESH`. A difference equal to `THRESH` is not flagged.
- R3: When `approx` is above `golden`, the flag is set only when (`approx` - `golden`) is greater than `THRESH`. A difference equal to `THRESH` is not flagged.
- R4: With `THRESH = 0`, any pair of unequal operands is flagged.
- R5: With `THRESH = 2**W - 1`, no operand pair is ever flagged.
- R6: A beat accepted on a clock edge makes `out_valid` high after that edge, with its verdict on `out_flag`.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid` and `out_flag` keep their values.
- R8: After reset, `out_valid` and `out_flag` are 0 and `in_ready` is 1.
- R9: Equal operands are never flagged, whatever the value of `THRESH`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair is presented |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| golden | input | W | Exact result, unsigned |
| approx | input | W | Approximate result, unsigned |
| out_valid | output | 1 | Verdict register holds a result |
| out_ready | input | 1 | Consumer takes the verdict this cycle |
| out_flag | output | 1 | 1 when the magnitude of the difference is greater than THRESH |

## Verification
The bench builds four copies of the block at `W = 6`, with `THRESH` set to 5, 0, 1 and 63. All four share the same stimulus, so every one of the 4096 operand pairs is checked against each tolerance. That brings within reach both edges of the positive and negative ranges, the degenerate tolerance of zero, and a tolerance that no difference can exceed. A separate stall sequence holds `out_ready` low while new input waits, which checks that the verdict is held and input is blocked.

// File: rtl/wce_pkg.sv
package wce_pkg;

  // Constant used by the negative-side test: THRESH-1, clamped at zero.
  function automatic int neg_bound(input int thresh);
    return (thresh > 0) ? thresh - 1 : 0;
  endfunction

  // Largest unsigned value representable in w bits.
  function automatic longint max_of(input int w);
    return (longint'(1) << w) - 1;
  endfunction

endpackage

// File: rtl/wce_const_gt.sv
// Strictly-greater comparison of a variable vector against a constant,
// built from AND/OR terms only. For every position where the constant
// holds a 0, the variable wins if its bit there is 1 and it matches all
// constant 1-bits above that position.
module wce_const_gt #(
  parameter int W = 6,
  parameter logic [W-1:0] K = '0
) (
  input  logic [W-1:0] a,
  output logic         gt
);
  logic [W:0]   hi_ok;
  logic [W-1:0] term;

  assign hi_ok[W] = 1'b1;

  for (genvar i = W - 1; i >= 0; i--) begin : g_bit
    if (K[i]) begin : g_one
      assign hi_ok[i] = hi_ok[i+1] & a[i];
      assign term[i]  = 1'b0;
    end else begin : g_zero
      assign hi_ok[i] = hi_ok[i+1];
      assign term[i]  = a[i] & hi_ok[i+1];
    end
  end

  assign gt = |term;
endmodule

// File: rtl/wce_diff.sv
// Signed difference golden - approx, one bit wider than the operands.
module wce_diff #(
  parameter int W = 6
) (
  input  logic [W-1:0] golden,
  input  logic [W-1:0] approx,
  output logic         neg,
  output logic [W-1:0] mag_bits
);
  logic [W:0] d;

  assign d        = {1'b0, golden} - {1'b0, approx};
  assign neg      = d[W];
  assign mag_bits = d[W-1:0];
endmodule

// File: rtl/wce_range.sv
// Sign-split threshold test on the difference.
module wce_range #(
  parameter int W      = 6,
  parameter int THRESH = 5
) (
  input  logic         neg,
  input  logic [W-1:0] low,
  output logic         viol
);
  import wce_pkg::*;

  localparam logic [W-1:0] K_POS = THRESH[W-1:0];
  localparam logic [W-1:0] K_NEG = W'(neg_bound(THRESH));

  logic pos_hit;
  logic neg_hit;
  logic [W-1:0] low_n;

  assign low_n = ~low;

  wce_const_gt #(.W(W), .K(K_POS)) u_pos (
    .a  (low),
    .gt (pos_hit)
  );

  if (THRESH == 0) begin : g_zero_tol
    // A negative difference is never zero, so it always exceeds 0.
    assign neg_hit = 1'b1;
  end else begin : g_tol
    wce_const_gt #(.W(W), .K(K_NEG)) u_neg (
      .a  (low_n),
      .gt (neg_hit)
    );
  end

  assign viol = neg ? neg_hit : pos_hit;

  always_comb begin
    if (!neg) begin
      AST_POS_BOUND: assert (pos_hit == (int'(low) > THRESH)); // R2
    end else begin
      AST_NEG_BOUND: assert (neg_hit == ((int'(low_n) + 1) > THRESH)); // R3
    end
  end
endmodule

// File: rtl/wce_guard.sv
module wce_guard #(
  parameter int W      = 6,
  parameter int THRESH = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] golden,
  input  logic [W-1:0] approx,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         out_flag
);
  import wce_pkg::*;

  logic         d_neg;
  logic [W-1:0] d_low;
  logic         viol;
  logic         take;

  wce_diff #(.W(W)) u_diff (
    .golden   (golden),
    .approx   (approx),
    .neg      (d_neg),
    .mag_bits (d_low)
  );

  wce_range #(.W(W), .THRESH(THRESH)) u_range (
    .neg  (d_neg),
    .low  (d_low),
    .viol (viol)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_flag  <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_flag  <= viol;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flag))); // R7

  AST_ACCEPT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R6

  AST_EQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (golden == approx)) |=> !out_flag); // R9

  if (longint'(THRESH) == max_of(W)) begin : g_max_chk
    AST_MAX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !out_flag); // R5
  end
endmodule

// File: tb/wce_guard_tb.sv
module wce_guard_tb;
  localparam int W        = 6;
  localparam int CLK_PER  = 10;
  localparam int NDUT     = 4;
  localparam int TV [NDUT] = '{5, 0, 1, 63};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [W-1:0] golden = '0;
  logic [W-1:0] approx = '0;
  logic [NDUT-1:0] rdy, ov, fl;

  int errors = 0;
  int checks = 0;

  always #(CLK_PER/2) clk = ~clk;

  wce_guard #(.W(W), .THRESH(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[0]),
    .golden(golden), .approx(approx), .out_valid(ov[0]),
    .out_ready(out_ready), .out_flag(fl[0]));
  wce_guard #(.W(W), .THRESH(0)) u_dut_t0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[1]),
    .golden(golden), .approx(approx), .out_valid(ov[1]),
    .out_ready(out_ready), .out_flag(fl[1]));
  wce_guard #(.W(W), .THRESH(1)) u_dut_t1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[2]),
    .golden(golden), .approx(approx), .out_valid(ov[2]),
    .out_ready(out_ready), .out_flag(fl[2]));
  wce_guard #(.W(W), .THRESH(63)) u_dut_tmax (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[3]),
    .golden(golden), .approx(approx), .out_valid(ov[3]),
    .out_ready(out_ready), .out_flag(fl[3]));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (g=%0d a=%0d)",
               req, act, exp, golden, approx);
    end
  endtask

  function automatic int expect_flag(input int g, input int a, input int t);
    int d = g - a;
    if (d < 0) d = -d;
    return (d > t) ? 1 : 0;
  endfunction

  function automatic string tag_for(input int k, input int g, input int a);
    if (g == a) return "R9";
    if (TV[k] == 0) return "R4";
    if (TV[k] == 63) return "R5";
    if (g > a) return "R2";
    return "R3";
  endfunction

  // Present one pair, wait for acceptance, check the registered verdicts.
  task automatic send(input int g, input int a);
    @(negedge clk);
    golden   = W'(g);
    approx   = W'(a);
    in_valid = 1'b1;
    while (!rdy[0]) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int k = 0; k < NDUT; k++) begin
      check("R6", int'(ov[k]), 1);
      check(tag_for(k, g, a), int'(fl[k]), expect_flag(g, a, TV[k])); // R1
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    for (int k = 0; k < NDUT; k++) begin
      check("R8", int'(ov[k]), 0);
      check("R8", int'(fl[k]), 0);
      check("R8", int'(rdy[k]), 1);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1..R5, R9: exhaustive sweep
    for (int g = 0; g < (1 << W); g++)
      for (int a = 0; a < (1 << W); a++)
        send(g, a);

    // R7: stall holds the verdict and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    golden = 6'd20; approx = 6'd10; in_valid = 1'b1;
    @(negedge clk);
    check("R6", int'(ov[0]), 1);
    check("R7", int'(fl[0]), 1);
    golden = 6'd10; approx = 6'd10;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R7", int'(rdy[0]), 0);
      check("R7", int'(ov[0]), 1);
      check("R7", int'(fl[0]), 1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7", int'(ov[0]), 1);
    check("R9", int'(fl[0]), 0);
    @(negedge clk);
    check("R7", int'(ov[0]), 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule